// File: doc/BRIEF.md
# Buffered Full-Duplex Framed Serial Port

This block is a synchronous serial port with two sections that work at the same time and do not depend on each other. Each section has its own bit clock and its own frame-sync input. The transmit section takes a word that the host writes into a holding register. At the start of a frame it moves that word into a shift register and sends it out on one data pin, most significant bit first. The receive section collects bits from its data pin in a shift register. It passes each finished word to a one-word buffer and then to a register the host reads. Because of this, one word can wait for the host while the next word is still arriving.

All logic runs on one system clock. The bit clocks, frame syncs and receive data are brought into that clock through synchronizer stages, and each section acts on the rising edges of its own bit clock. The host sets the word length at run time with a length input; values outside the supported range are clamped. Ready flags handshake with the host in both directions, and an overrun flag reports a word that had to be dropped.

Top module: `fdx_serial_port`

## Requirements
- R1: After reset, tx_ready is 1, rx_ready is 0, rx_overrun is 0, tx_dout is 0 and rx_rdata is 0.
- R2: On a tx_bclk rising edge where tx_fs is 1, a frame starts. tx_dout then carries the word's bits, most significant first, and each bit is updated on one of the next L rising edges, where L is the effective length. Bit L-1 is the first bit out.
- R3: On an rx_bclk rising edge where rx_fs is 1, a frame starts. rx_din is then sampled on each of the next L rising edges, most significant bit first. The finished word appears in the low L bits of rx_rdata, and the upper bits of rx_rdata are 0.
- R4: A tx_wr pulse clears tx_ready on the next cycle. This holds even if a frame start moves the holding word in the same cycle.
- R5: tx_ready returns to 1 when a frame start moves the holding word into the shift register. If no write came in between, the next frame sends the same word again.
- R6: rx_ready rises when a word reaches rx_rdata. An rx_rd pulse while rx_ready is 1 clears it on the next cycle.
- R7: If a second word finishes while rx_ready is still 1, it waits in the buffer and rx_rdata does not change. After the host reads, that word moves into rx_rdata and rx_ready rises again.
- R8: If a word finishes while the buffer is still full, rx_overrun goes to 1 and the new word is dropped. An rx_rd pulse clears rx_overrun.
- R9: The effective length L is word_len clamped to the range 8 to 32. Only the low L bits of tx_wdata are sent.
- R10: The two sections run independently at the same time, each with its own bit-clock rate. A frame on one side leaves the other side's flags and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_len | input | 6 | Requested word length in bits; clamped to 8..32 |
| tx_wr | input | 1 | Host write strobe for the transmit holding register |
| tx_wdata | input | 32 | Word to transmit; the low L bits are used |
| tx_ready | output | 1 | Holding register is free for a new word |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_dout | output | 1 | Serial transmit data |
| rx_rd | input | 1 | Host read strobe for the receive data register |
| rx_rdata | output | 32 | Last received word, right-justified |
| rx_ready | output | 1 | rx_rdata holds a word the host has not read |
| rx_overrun | output | 1 | A received word was dropped because the buffer was full |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |

## Verification
The bench runs a loopback-free duplex frame for each table entry, with the two bit clocks at different rates. This shows whether a shared or swapped clock path corrupts either word. It includes lengths below 8 and above 32, which catches missing or inverted clamping as a wrong bit count. A write with junk in the upper bits catches a transmitter that sends bits outside the word. Three receive words arrive without a read; a design without the buffer stage would lose the second word, and one without overrun detection would overwrite the waiting word or leave the flag low. A frame with no new write checks that the old word is sent again and not zero, and that tx_ready stays set.

// File: rtl/fdx_sport_pkg.sv
package fdx_sport_pkg;

   // Clamp a requested word length into the supported window.
   function automatic int unsigned clamp_len(input int unsigned req,
                                             input int unsigned lo,
                                             input int unsigned hi);
      if (req < lo)      return lo;
      else if (req > hi) return hi;
      else               return req;
   endfunction

endpackage

// File: rtl/fdx_sport_sync.sv
module fdx_sport_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fdx_sport_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '0;
               else        pipe[s] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '0;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/fdx_sport_tx.sv
module fdx_sport_tx #(
   parameter int MAX_W = 32,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] eff_len,
   input  logic             host_wr,
   input  logic [MAX_W-1:0] host_data,
   output logic             host_ready,
   input  logic             bclk_s,
   input  logic             fs_s,
   output logic             ser_out
);

   logic             bclk_q;
   logic             bit_edge;
   logic             frame_go;
   logic [MAX_W-1:0] hold_q;
   logic [MAX_W-1:0] shreg_q;
   logic [LEN_W-1:0] left_q;

   assign bit_edge = bclk_s & ~bclk_q;
   assign frame_go = bit_edge & fs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk_s;
   end

   // Holding register and its ready flag; a write wins over a same-cycle load.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= '0;
         host_ready <= 1'b1;
      end else begin
         if (host_wr) hold_q <= host_data;
         if (host_wr)       host_ready <= 1'b0;
         else if (frame_go) host_ready <= 1'b1;
      end
   end

   // Shift register, left-aligned so the word's top bit sits at MAX_W-1.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
         ser_out <= 1'b0;
      end else if (frame_go) begin
         shreg_q <= hold_q << (LEN_W'(MAX_W) - eff_len);
         left_q  <= eff_len;
         ser_out <= 1'b0;
      end else if (bit_edge) begin
         if (left_q != '0) begin
            ser_out <= shreg_q[MAX_W-1];
            shreg_q <= shreg_q << 1;
            left_q  <= left_q - LEN_W'(1);
         end else begin
            ser_out <= 1'b0;
         end
      end
   end

   // R4: a host write always leaves the holding register not ready.
   a_r4_wr_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> !host_ready);

   // R5: a frame start with no competing write frees the holding register.
   a_r5_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_go && !host_wr) |=> host_ready);

   // R2: the serial output moves only on bit-clock edges.
   a_r2_dout_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_edge |=> $stable(ser_out));

endmodule

// File: rtl/fdx_sport_rx.sv
module fdx_sport_rx #(
   parameter int MAX_W = 32,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] eff_len,
   input  logic             bclk_s,
   input  logic             fs_s,
   input  logic             din_s,
   input  logic             host_rd,
   output logic [MAX_W-1:0] host_data,
   output logic             host_ready,
   output logic             overrun
);

   logic             bclk_q;
   logic             bit_edge;
   logic             frame_go;
   logic             word_done;
   logic             buf_move;
   logic             buf_free;
   logic             buf_full_q;
   logic [MAX_W-1:0] shreg_q;
   logic [MAX_W-1:0] next_word;
   logic [MAX_W-1:0] buf_q;
   logic [LEN_W-1:0] left_q;

   assign bit_edge  = bclk_s & ~bclk_q;
   assign frame_go  = bit_edge & fs_s;
   assign next_word = {shreg_q[MAX_W-2:0], din_s};
   assign word_done = bit_edge & ~fs_s & (left_q == LEN_W'(1));
   assign buf_move  = buf_full_q & ~host_ready;
   assign buf_free  = ~buf_full_q | buf_move;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk_s;
   end

   // Deserializer: cleared at frame start so short words read back zero-extended.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
      end else if (frame_go) begin
         shreg_q <= '0;
         left_q  <= eff_len;
      end else if (bit_edge && left_q != '0) begin
         shreg_q <= next_word;
         left_q  <= left_q - LEN_W'(1);
      end
   end

   // Middle stage: one word waiting for the host register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q      <= '0;
         buf_full_q <= 1'b0;
      end else begin
         if (word_done && buf_free) buf_q <= next_word;
         buf_full_q <= (buf_full_q & ~buf_move) | (word_done & buf_free);
      end
   end

   // Host-visible register, ready flag and sticky overrun.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_data  <= '0;
         host_ready <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         if (buf_move) host_data <= buf_q;
         if (buf_move)     host_ready <= 1'b1;
         else if (host_rd) host_ready <= 1'b0;
         if (word_done && !buf_free) overrun <= 1'b1;
         else if (host_rd)           overrun <= 1'b0;
      end
   end

   // R6: a read of a ready word drops the flag on the next cycle.
   a_r6_rd_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_ready) |=> !host_ready);

   // R7: the host register changes only by a transfer from the buffer.
   a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_move |=> $stable(host_data));

   // R6: the ready flag rises only after the buffer held a word.
   a_r6_ready_from_buf: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ready) |-> $past(buf_full_q));

   // R8: a word completing against a full buffer raises overrun.
   a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && buf_full_q && !buf_move) |=> overrun);

endmodule

// File: rtl/fdx_serial_port.sv
module fdx_serial_port #(
   parameter int MIN_W       = 8,
   parameter int MAX_W       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] word_len,
   input  logic             tx_wr,
   input  logic [MAX_W-1:0] tx_wdata,
   output logic             tx_ready,
   input  logic             tx_bclk,
   input  logic             tx_fs,
   output logic             tx_dout,
   input  logic             rx_rd,
   output logic [MAX_W-1:0] rx_rdata,
   output logic             rx_ready,
   output logic             rx_overrun,
   input  logic             rx_bclk,
   input  logic             rx_fs,
   input  logic             rx_din
);

   generate
      if (MIN_W < 2) begin : g_bad_min
         $error("fdx_serial_port: MIN_W must be at least 2");
      end
      if (MAX_W < MIN_W) begin : g_bad_max
         $error("fdx_serial_port: MAX_W must not be below MIN_W");
      end
      if ((2 ** LEN_W) <= MAX_W) begin : g_bad_len
         $error("fdx_serial_port: LEN_W too narrow for MAX_W");
      end
   endgenerate

   logic [LEN_W-1:0] eff_len;
   logic [1:0]       tx_sync;
   logic [2:0]       rx_sync;

   assign eff_len = LEN_W'(fdx_sport_pkg::clamp_len(int'(word_len), MIN_W, MAX_W));

   fdx_sport_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_tx_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({tx_bclk, tx_fs}),
      .sync_out (tx_sync)
   );

   fdx_sport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_rx_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({rx_bclk, rx_fs, rx_din}),
      .sync_out (rx_sync)
   );

   fdx_sport_tx #(.MAX_W(MAX_W), .LEN_W(LEN_W)) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .eff_len    (eff_len),
      .host_wr    (tx_wr),
      .host_data  (tx_wdata),
      .host_ready (tx_ready),
      .bclk_s     (tx_sync[1]),
      .fs_s       (tx_sync[0]),
      .ser_out    (tx_dout)
   );

   fdx_sport_rx #(.MAX_W(MAX_W), .LEN_W(LEN_W)) i_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .eff_len    (eff_len),
      .bclk_s     (rx_sync[2]),
      .fs_s       (rx_sync[1]),
      .din_s      (rx_sync[0]),
      .host_rd    (rx_rd),
      .host_data  (rx_rdata),
      .host_ready (rx_ready),
      .overrun    (rx_overrun)
   );

   // R9: the length used by both sections stays inside the supported window.
   a_r9_len_window: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_len >= LEN_W'(MIN_W)) && (eff_len <= LEN_W'(MAX_W)));

endmodule

// File: tb/test_fdx_serial_port.sv
`timescale 1ns/1ps
module test_fdx_serial_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  word_len = 6'd8;
   logic        tx_wr = 1'b0;
   logic [31:0] tx_wdata = '0;
   logic        tx_ready;
   logic        tx_bclk = 1'b0;
   logic        tx_fs = 1'b0;
   logic        tx_dout;
   logic        rx_rd = 1'b0;
   logic [31:0] rx_rdata;
   logic        rx_ready;
   logic        rx_overrun;
   logic        rx_bclk = 1'b0;
   logic        rx_fs = 1'b0;
   logic        rx_din = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fdx_serial_port i_fdx_serial_port (
      .clk(clk), .rst_n(rst_n), .word_len(word_len),
      .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_ready(tx_ready),
      .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_dout(tx_dout),
      .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_ready(rx_ready),
      .rx_overrun(rx_overrun), .rx_bclk(rx_bclk), .rx_fs(rx_fs),
      .rx_din(rx_din)
   );

   localparam int NV = 6;
   localparam logic [5:0]  V_LEN [NV] = '{6'd8, 6'd16, 6'd32, 6'd12, 6'd4, 6'd40};
   localparam logic [31:0] V_TX  [NV] = '{32'h0000_00A5, 32'h0000_BEEF, 32'hDEAD_BEEF,
                                          32'hABCD_EF0F, 32'h1234_5681, 32'h0F1E_2D3C};
   localparam logic [31:0] V_RX  [NV] = '{32'h0000_003C, 32'h0000_1234, 32'h8000_0001,
                                          32'h0000_05A5, 32'h0000_00C3, 32'hFFFF_0000};

   function automatic int eff_of(input logic [5:0] l);
      if (l < 6'd8)  return 8;
      if (l > 6'd32) return 32;
      return int'(l);
   endfunction

   function automatic logic [31:0] mask_of(input int l);
      return (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 32'h1);
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic [31:0] d);
      @(negedge clk);
      tx_wr    = 1'b1;
      tx_wdata = d;
      @(negedge clk);
      tx_wr    = 1'b0;
   endtask

   task automatic host_read();
      @(negedge clk);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   // Transmit frame: sync period, L data periods, one idle period.
   task automatic tx_frame(input int len, input int half, output logic [31:0] got);
      got = '0;
      for (int p = 0; p <= len + 1; p++) begin
         @(negedge clk);
         tx_fs = (p == 0);
         wait_clk(half);
         tx_bclk = 1'b1;
         wait_clk(half - 2);
         if (p >= 1 && p <= len) got = {got[30:0], tx_dout};
         wait_clk(2);
         tx_bclk = 1'b0;
      end
   endtask

   // Receive frame: drive the word MSB first, one bit per period.
   task automatic rx_frame(input int len, input int half, input logic [31:0] w);
      for (int p = 0; p <= len + 1; p++) begin
         @(negedge clk);
         rx_fs  = (p == 0);
         rx_din = (p >= 1 && p <= len) ? w[len - p] : 1'b0;
         wait_clk(half);
         rx_bclk = 1'b1;
         wait_clk(half);
         rx_bclk = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] got;
      int          el;
      wait_clk(5);
      // R1: reset values observed while reset is held
      check(tx_ready == 1'b1,   "R1", {31'b0, tx_ready},   32'h1);
      check(rx_ready == 1'b0,   "R1", {31'b0, rx_ready},   32'h0);
      check(rx_overrun == 1'b0, "R1", {31'b0, rx_overrun}, 32'h0);
      check(tx_dout == 1'b0,    "R1", {31'b0, tx_dout},    32'h0);
      check(rx_rdata == 32'h0,  "R1", rx_rdata,            32'h0);
      rst_n = 1'b1;
      wait_clk(4);

      // Table walk: each entry runs a transmit and a receive frame in parallel at different rates (R10)
      for (int v = 0; v < NV; v++) begin
         word_len = V_LEN[v];
         el = eff_of(V_LEN[v]);
         host_write(V_TX[v]);
         check(tx_ready == 1'b0, "R4", {31'b0, tx_ready}, 32'h0);
         fork
            tx_frame(el, 8, got);
            rx_frame(el, 12, V_RX[v] & mask_of(el));
         join
         wait_clk(6);
         check(got == (V_TX[v] & mask_of(el)), "R2 R9 R10", got, V_TX[v] & mask_of(el));
         check(tx_ready == 1'b1, "R5", {31'b0, tx_ready}, 32'h1);
         check(rx_ready == 1'b1, "R6", {31'b0, rx_ready}, 32'h1);
         check(rx_rdata == (V_RX[v] & mask_of(el)), "R3 R10", rx_rdata, V_RX[v] & mask_of(el));
         host_read();
         wait_clk(2);
         check(rx_ready == 1'b0, "R6", {31'b0, rx_ready}, 32'h0);
      end

      // R5: no write since the last frame, so the old word is resent
      word_len = 6'd16;
      tx_frame(16, 8, got);
      wait_clk(4);
      check(got == 32'h0000_2D3C, "R5", got, 32'h0000_2D3C);
      check(tx_ready == 1'b1, "R5", {31'b0, tx_ready}, 32'h1);
      // R10: a transmit frame leaves the receive side idle
      check(rx_ready == 1'b0, "R10", {31'b0, rx_ready}, 32'h0);

      // R7 / R8: three receive words with no read in between
      word_len = 6'd8;
      rx_frame(8, 8, 32'h11);
      wait_clk(6);
      check(rx_rdata == 32'h11, "R6", rx_rdata, 32'h11);
      rx_frame(8, 8, 32'h22);
      wait_clk(6);
      check(rx_rdata == 32'h11, "R7", rx_rdata, 32'h11);
      check(rx_overrun == 1'b0, "R7", {31'b0, rx_overrun}, 32'h0);
      rx_frame(8, 8, 32'h33);
      wait_clk(6);
      check(rx_overrun == 1'b1, "R8", {31'b0, rx_overrun}, 32'h1);
      check(rx_rdata == 32'h11, "R8", rx_rdata, 32'h11);
      host_read();
      wait_clk(4);
      check(rx_ready == 1'b1,   "R7", {31'b0, rx_ready},   32'h1);
      check(rx_rdata == 32'h22, "R7", rx_rdata,            32'h22);
      check(rx_overrun == 1'b0, "R8", {31'b0, rx_overrun}, 32'h0);
      host_read();
      wait_clk(6);
      check(rx_ready == 1'b0,   "R8", {31'b0, rx_ready}, 32'h0);
      check(rx_rdata == 32'h22, "R8", rx_rdata,          32'h22);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule